// File: doc/BRIEF.md
# Flyback Charge Cycle Supervisor

This block sequences the power switch of a flyback capacitor charger. It sits behind the analog front end and receives already-digitised comparator flags: primary current limit, a one-cycle pulse that marks the end of secondary conduction (the discontinuous-mode one-shot), and an output-target-reached flag. It also receives six lockout flags and a charge enable input. The lockout flags are undervoltage and overvoltage on each of the two supplies, internal undervoltage and die overtemperature. From these inputs it drives a gate-enable output and two active-low status outputs. The status outputs are low when asserted, as an open-drain pull-down would be.

A qualified rising edge on the charge enable input arms a start-up one-shot. After a parameterised delay the one-shot sets the master enable and switch latches. Current limit ends each on-phase. The discontinuous-mode pulse starts the next on-phase. The target flag, when it is seen during secondary transfer, stops the sequence and reports completion. Any lockout trips a sticky fault. The fault can only be cleared by a new, qualified low-then-high cycle of the charge enable input, and only while no lockout is present.

Top module: `flyback_charge_seq`

## Requirements
- R1: After a qualified rise of `charge_i`, `gate_en_o` goes high on the (START_DLY+3)th rising clock edge after the change and not earlier; the three extra edges are two synchroniser stages and one edge detector.
- R2: A rise of `charge_i` is accepted only if the synchronised charge input was low for at least MIN_LOW consecutive clocks just before it; a shorter low, including the time just after reset, is ignored and `gate_en_o` stays low.
- R3: `ilim_i` high at a clock edge clears the switch latch, so `gate_en_o` is low after that edge; it overrides a discontinuous-mode pulse in the same cycle.
- R4: A `dcm_os_i` pulse while the master latch is set and the switch latch is clear sets the switch latch; `gate_en_o` is high after that edge.
- R5: `vtgt_i` has no effect while the switch latch is set: `gate_en_o` stays high and `done_n_o` stays high.
- R6: `vtgt_i` high at an edge while the master latch is set and the switch latch is clear resets the master latch; after that edge `done_n_o` is low and `gate_en_o` is low.
- R7: After completion, `dcm_os_i` pulses are ignored and `gate_en_o` stays low until a new accepted start.
- R8: Any bit of `lock_i` (bits 0 to 5; any one of them is a fault) that is high trips the fault latch on the third rising edge after it is asserted; `fault_n_o` and `done_n_o` then go low and `gate_en_o` goes low.
- R9: The fault stays latched after every lockout has cleared, and until `charge_i` is taken low for a valid low time and then high again; that accepted rise also clears the done state.
- R10: `charge_i` low stops switching: `gate_en_o` is low from the third rising edge after the fall. The done state is kept during shutdown.
- R11: If a lockout is still present when a rise is accepted, the fault stays set and no switching starts.
- R12: While `rst` is high, `gate_en_o` is low, and `done_n_o` and `fault_n_o` are high after the next edge.
- R13: `gate_en_o` is never high while `done_n_o` or `fault_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| charge_i | input | 1 | Charge enable, asynchronous |
| ilim_i | input | 1 | Primary current limit flag, synchronous |
| dcm_os_i | input | 1 | Discontinuous-mode one-shot pulse, synchronous |
| vtgt_i | input | 1 | Output target reached flag, synchronous |
| lock_i | input | 6 | Lockout flags, asynchronous: 0 transformer supply undervoltage, 1 transformer supply overvoltage, 2 control supply undervoltage, 3 control supply overvoltage, 4 internal undervoltage, 5 overtemperature |
| gate_en_o | output | 1 | Switch gate enable, registered |
| done_n_o | output | 1 | Active-low completion or fault indication, registered |
| fault_n_o | output | 1 | Active-low fault indication, registered |

## Verification
Each result has a fixed latency that the bench uses as a cycle count. Switch flags (current limit, discontinuous-mode pulse, target) show at the outputs after one edge. The lockout flags and a fall of the charge input show after three edges. An accepted start shows at the gate after START_DLY+3 edges. Every vector in the stimulus table drives the inputs on a falling edge, waits a stated number of rising edges and samples on the next falling edge. For each of these timings one vector samples one edge before the output is due to change and another samples on the edge where it changes.

// File: rtl/fb_pkg.sv
package fb_pkg;
  // Lockout flag positions on the lockout bus
  typedef enum int unsigned {
    LK_XFMR_UV = 0,
    LK_XFMR_OV = 1,
    LK_CTRL_UV = 2,
    LK_CTRL_OV = 3,
    LK_INT_UV  = 4,
    LK_HOT     = 5
  } lock_idx_e;

  localparam int unsigned NUM_LOCK = 6;

  // Latch state of the supervisor
  typedef struct packed {
    logic master;
    logic sw;
    logic fault;
    logic done;
  } latch_t;
endpackage

// File: rtl/fb_sync.sv
module fb_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  // Per-bit two-stage synchroniser
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk) begin
      if (rst) begin
        s1 <= 1'b0;
        s2 <= 1'b0;
      end else begin
        s1 <= d_i[b];
        s2 <= s1;
      end
    end
    assign q_o[b] = s2;
  end
endmodule

// File: rtl/fb_charge_qual.sv
module fb_charge_qual #(
  parameter int unsigned MIN_LOW   = 1000,
  parameter int unsigned START_DLY = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,    // synchronised charge enable
  output logic start_o,  // accepted rising edge
  output logic fire_o    // start-up one-shot expiry
);
  localparam int unsigned LW = $clog2(MIN_LOW + 1);
  localparam int unsigned DW = $clog2(START_DLY + 1);

  logic          run_d;
  logic [LW-1:0] low_cnt;
  logic [DW-1:0] dly;
  logic          armed;

  assign armed   = (low_cnt == LW'(MIN_LOW));
  assign start_o = run_i & ~run_d & armed;
  assign fire_o  = run_i & (dly == DW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_d   <= 1'b0;
      low_cnt <= '0;
      dly     <= '0;
    end else begin
      run_d <= run_i;
      if (!run_i) begin
        if (!armed) low_cnt <= low_cnt + LW'(1);
      end else begin
        low_cnt <= '0;
      end
      if (!run_i)          dly <= '0;
      else if (start_o)    dly <= DW'(START_DLY);
      else if (dly != '0)  dly <= dly - DW'(1);
    end
  end
endmodule

// File: rtl/fb_latch_core.sv
module fb_latch_core
  import fb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic fire_i,
  input  logic run_i,
  input  logic lock_any_i,
  input  logic ilim_i,
  input  logic dcm_i,
  input  logic vtgt_i,
  output logic gate_o,
  output logic done_n_o,
  output logic fault_n_o
);
  latch_t cur, nxt;
  logic   hit;
  logic   gate_q, done_n_q, fault_n_q;

  always_comb begin
    nxt = cur;
    hit = cur.master & ~cur.sw & vtgt_i;
    // fault latch: set while any lockout, cleared only by accepted start
    nxt.fault = lock_any_i | (cur.fault & ~start_i);
    // master enable latch
    if (fire_i & ~nxt.fault) nxt.master = 1'b1;
    if (hit)                 nxt.master = 1'b0;
    if (nxt.fault | ~run_i)  nxt.master = 1'b0;
    // completion state
    if (start_i)  nxt.done = 1'b0;
    else if (hit) nxt.done = 1'b1;
    // switch latch
    if (fire_i & ~nxt.fault)                      nxt.sw = 1'b1;
    if (cur.master & ~cur.sw & dcm_i & ~vtgt_i)   nxt.sw = 1'b1;
    if (ilim_i)                                   nxt.sw = 1'b0;
    if (!nxt.master)                              nxt.sw = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      gate_q    <= 1'b0;
      done_n_q  <= 1'b1;
      fault_n_q <= 1'b1;
    end else begin
      cur       <= nxt;
      gate_q    <= nxt.master & nxt.sw & ~nxt.fault;
      done_n_q  <= ~(nxt.done | nxt.fault);
      fault_n_q <= ~nxt.fault;
    end
  end

  assign gate_o    = gate_q;
  assign done_n_o  = done_n_q;
  assign fault_n_o = fault_n_q;
endmodule

// File: rtl/flyback_charge_seq.sv
module flyback_charge_seq
  import fb_pkg::*;
#(
  parameter int unsigned MIN_LOW   = 1000,
  parameter int unsigned START_DLY = 100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                charge_i,
  input  logic                ilim_i,
  input  logic                dcm_os_i,
  input  logic                vtgt_i,
  input  logic [NUM_LOCK-1:0] lock_i,
  output logic                gate_en_o,
  output logic                done_n_o,
  output logic                fault_n_o
);
  localparam int unsigned SW = NUM_LOCK + 1;

  logic [SW-1:0] sync_q;
  logic          run_s, lock_any, start, fire;

  fb_sync #(.W(SW)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({charge_i, lock_i}),
    .q_o (sync_q)
  );

  assign run_s    = sync_q[SW-1];
  assign lock_any = |sync_q[NUM_LOCK-1:0];

  fb_charge_qual #(.MIN_LOW(MIN_LOW), .START_DLY(START_DLY)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run_s),
    .start_o (start),
    .fire_o  (fire)
  );

  fb_latch_core u_core (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .fire_i     (fire),
    .run_i      (run_s),
    .lock_any_i (lock_any),
    .ilim_i     (ilim_i),
    .dcm_i      (dcm_os_i),
    .vtgt_i     (vtgt_i),
    .gate_o     (gate_en_o),
    .done_n_o   (done_n_o),
    .fault_n_o  (fault_n_o)
  );
endmodule

// File: rtl/fb_seq_checker.sv
module fb_seq_checker #(
  parameter int unsigned NL = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          charge_i,
  input logic          ilim_i,
  input logic [NL-1:0] lock_i,
  input logic          gate_en_o,
  input logic          done_n_o,
  input logic          fault_n_o
);
  logic [1:0] age;
  logic       ready;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign ready = (age == 2'd3);

  assert_gate_clean_R13: assert property (@(posedge clk) disable iff (rst)
    gate_en_o |-> (done_n_o && fault_n_o));

  assert_ilim_cut_R3: assert property (@(posedge clk) disable iff (rst)
    ilim_i |=> !gate_en_o);

  assert_lock_trip_R8: assert property (@(posedge clk) disable iff (rst)
    (ready && $past(|lock_i, 2)) |=> !fault_n_o);

  assert_fault_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (ready && !fault_n_o && !charge_i && !$past(charge_i) && !$past(charge_i, 2))
      |=> !fault_n_o);

  assert_shutdown_R10: assert property (@(posedge clk) disable iff (rst)
    (ready && !$past(charge_i) && !$past(charge_i, 2)) |=> !gate_en_o);
endmodule

bind flyback_charge_seq fb_seq_checker #(.NL(fb_pkg::NUM_LOCK)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .charge_i  (charge_i),
  .ilim_i    (ilim_i),
  .lock_i    (lock_i),
  .gate_en_o (gate_en_o),
  .done_n_o  (done_n_o),
  .fault_n_o (fault_n_o)
);

// File: tb/flyback_charge_seq_bench.sv
module flyback_charge_seq_bench;
  localparam int unsigned MIN_LOW   = 8;
  localparam int unsigned START_DLY = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       charge_i = 1'b0, ilim_i = 1'b0, dcm_os_i = 1'b0, vtgt_i = 1'b0;
  logic [5:0] lock_i = '0;
  logic       gate_en_o, done_n_o, fault_n_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  flyback_charge_seq #(.MIN_LOW(MIN_LOW), .START_DLY(START_DLY)) u_flyback_charge_seq (
    .clk(clk), .rst(rst), .charge_i(charge_i), .ilim_i(ilim_i),
    .dcm_os_i(dcm_os_i), .vtgt_i(vtgt_i), .lock_i(lock_i),
    .gate_en_o(gate_en_o), .done_n_o(done_n_o), .fault_n_o(fault_n_o)
  );

  typedef struct packed {
    logic       chg, ilim, dcm, vtgt;
    logic [5:0] lock;
    logic [4:0] wt;
    logic       eg, edn, efn;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 28;
  localparam vec_t TBL [NV] = '{
    '{1'b0,1'b0,1'b0,1'b0,6'h00,5'd12,1'b0,1'b1,1'b1,4'd12}, // R12 idle after reset
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd6, 1'b0,1'b1,1'b1,4'd1},  // R1 one edge early
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd1, 1'b1,1'b1,1'b1,4'd1},  // R1 on time
    '{1'b1,1'b1,1'b0,1'b0,6'h00,5'd1, 1'b0,1'b1,1'b1,4'd3},  // R3 current limit
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd3, 1'b0,1'b1,1'b1,4'd3},  // R3 stays off
    '{1'b1,1'b0,1'b1,1'b0,6'h00,5'd1, 1'b1,1'b1,1'b1,4'd4},  // R4 dcm restarts
    '{1'b1,1'b0,1'b0,1'b1,6'h00,5'd2, 1'b1,1'b1,1'b1,4'd5},  // R5 target while on
    '{1'b1,1'b1,1'b0,1'b1,6'h00,5'd1, 0,1'b1,1'b1,4'd5},     // R5 same edge as ilim
    '{1'b1,1'b0,1'b0,1'b1,6'h00,5'd1, 1'b0,1'b0,1'b1,4'd6},  // R6 done
    '{1'b1,1'b0,1'b1,1'b0,6'h00,5'd2, 1'b0,1'b0,1'b1,4'd7},  // R7 dcm ignored
    '{1'b0,1'b0,1'b0,1'b0,6'h00,5'd12,1'b0,1'b0,1'b1,4'd10}, // R10 done kept
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd3, 1'b0,1'b1,1'b1,4'd9},  // R9 start clears done
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd4, 1'b1,1'b1,1'b1,4'd1},  // R1 switching
    '{1'b1,1'b0,1'b0,1'b0,6'h04,5'd2, 1'b1,1'b1,1'b1,4'd8},  // R8 not yet
    '{1'b1,1'b0,1'b0,1'b0,6'h04,5'd1, 1'b0,1'b0,1'b0,4'd8},  // R8 tripped
    '{1'b1,1'b0,1'b1,1'b0,6'h00,5'd4, 1'b0,1'b0,1'b0,4'd9},  // R9 latched
    '{1'b0,1'b0,1'b0,1'b0,6'h00,5'd12,1'b0,1'b0,1'b0,4'd9},  // R9 low only
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd12,1'b1,1'b1,1'b1,4'd9},  // R9 toggle clears
    '{1'b0,1'b0,1'b0,1'b0,6'h00,5'd2, 1'b1,1'b1,1'b1,4'd10}, // R10 not yet
    '{1'b0,1'b0,1'b0,1'b0,6'h00,5'd1, 1'b0,1'b1,1'b1,4'd10}, // R10 off
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd10,1'b0,1'b1,1'b1,4'd2},  // R2 short low
    '{1'b0,1'b0,1'b0,1'b0,6'h20,5'd12,1'b0,1'b0,1'b0,4'd8},  // R8 overtemp
    '{1'b1,1'b0,1'b0,1'b0,6'h20,5'd12,1'b0,1'b0,1'b0,4'd11}, // R11 lock at start
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd12,1'b0,1'b0,1'b0,4'd9},  // R9 needs toggle
    '{1'b0,1'b0,1'b0,1'b0,6'h00,5'd12,1'b0,1'b0,1'b0,4'd9},  // R9 low
    '{1'b1,1'b0,1'b0,1'b0,6'h00,5'd12,1'b1,1'b1,1'b1,4'd9},  // R9 restart
    '{1'b1,1'b1,1'b1,1'b0,6'h00,5'd1, 1'b0,1'b1,1'b1,4'd3},  // R3 beats dcm
    '{1'b1,1'b0,1'b1,1'b0,6'h00,5'd1, 1'b1,1'b1,1'b1,4'd4}   // R4 dcm again
  };

  task automatic check(input logic [3:0] req, input int idx,
                       input logic g, input logic dn, input logic fn);
    n_chk++;
    if (gate_en_o !== g || done_n_o !== dn || fault_n_o !== fn) begin
      n_bad++;
      $display("FAIL R%0d vec %0d: got gate=%b done_n=%b fault_n=%b exp %b %b %b",
               req, idx, gate_en_o, done_n_o, fault_n_o, g, dn, fn);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(4'd12, -1, 1'b0, 1'b1, 1'b1); // R12 reset state
    rst = 1'b0;
    for (int i = 0; i < NV; i++) begin
      charge_i = TBL[i].chg; ilim_i = TBL[i].ilim; dcm_os_i = TBL[i].dcm;
      vtgt_i = TBL[i].vtgt; lock_i = TBL[i].lock;
      repeat (int'(TBL[i].wt)) @(posedge clk);
      @(negedge clk);
      check(TBL[i].req, i, TBL[i].eg, TBL[i].edn, TBL[i].efn);
      if (gate_en_o) check(4'd13, i, 1'b1, 1'b1, 1'b1); // R13 invariant
    end
    // R12: reset in the middle of switching
    ilim_i = 1'b0; dcm_os_i = 1'b0;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(4'd12, 100, 1'b0, 1'b1, 1'b1);
    // R2: charge held high through reset release is not a valid start
    rst = 1'b0;
    repeat (12) @(posedge clk); @(negedge clk);
    check(4'd2, 101, 1'b0, 1'b1, 1'b1);
    report();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
  end
endmodule